// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is a watchdog that counts ticks of a slow internal clock. An 8-bit base counter feeds a postscaler. The postscaler's ratio is chosen as a power of two by a 4-bit select. When the full count expires, the watchdog acts according to the power mode the device is in at that moment. While code executes (run mode), the expiry issues a one-cycle watchdog reset pulse. While the core is halted (idle or sleep), the same expiry issues a one-cycle wake pulse that brings the device back to execution.

The count restarts from zero on several hardware events, not only on the explicit clear instruction:
- the sleep instruction;
- a lost clock, but only when clock monitoring is on;
- a write to the internal frequency select, but only when the internal oscillator drives the system clock.

A sticky time-out flag records that an expiry occurred. A global enable holds the whole count at zero and silences both pulse outputs.

Top module: `pm_watchdog`

## Requirements
- R1: When the count expires with `pmode_i` at 01 (idle), 10 (sleep) or 11 (treated as idle), `wake_o` pulses and `rst_o` stays low.
- R2: When the count expires with `pmode_i` at 00 (run), `rst_o` pulses and `wake_o` stays low.
- R3: The count expires after 256 × 2^`ps_sel_i` ticks since the count was last zero. Only cycles with `tick_i` high advance the count.
- R4: `sleep_i` restarts the count from zero. It leaves `to_o` unchanged.
- R5: `clrwdt_i` restarts the count from zero and clears `to_o`.
- R6: `clk_lost_i` restarts the count only while `mon_en_i` is high. Otherwise it has no effect.
- R7: `freq_wr_i` restarts the count only while `intosc_sys_i` is high. Otherwise it has no effect.
- R8: Each pulse lasts exactly one cycle. It rises in the cycle after the clock edge that takes the terminal tick. `to_o` rises with the pulse and stays high until `clrwdt_i` or `rst_ni` clears it. All outputs are low out of reset.
- R9: A restart event in the same cycle as the terminal tick wins: no pulse is issued, and the count restarts from zero.
- R10: While `en_i` is low, the count is held at zero and no pulse is issued. Counting resumes from zero once `en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| en_i | input | 1 | Global watchdog enable |
| tick_i | input | 1 | One-cycle strobe per slow-clock period |
| pmode_i | input | 2 | Power mode: 00 run, 01 idle, 10 sleep, 11 idle |
| ps_sel_i | input | 4 | Postscaler select; ratio is 2^value |
| sleep_i | input | 1 | Sleep instruction executed |
| clrwdt_i | input | 1 | Clear-watchdog instruction executed |
| clk_lost_i | input | 1 | Selected clock source has failed |
| mon_en_i | input | 1 | Clock monitoring enabled |
| freq_wr_i | input | 1 | Internal frequency select written |
| intosc_sys_i | input | 1 | Internal oscillator is the system clock |
| wake_o | output | 1 | Wake pulse on expiry in a halted mode |
| rst_o | output | 1 | Reset pulse on expiry in run mode |
| to_o | output | 1 | Sticky time-out flag |

## Verification
The mode checks on the pulses assume `pmode_i` is stable across the cycle of the terminal tick. The stimulus changes the mode only together with a restart, far from any expiry.

The properties also assume that the event strobes are single cycles driven synchronously. The bench raises every strobe at a falling edge for exactly one cycle.

The postscaler select is never changed mid-count without a restart in the same cycle. This keeps every expected pulse time a plain multiple of 256 ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_HALT  = 2'd3
  } pmode_e;

  localparam int unsigned N_CLR_SRC = 4;
endpackage

// File: rtl/wdt_clr_gen.sv
module wdt_clr_gen
  import wdt_pkg::*;
(
  input  logic sleep_i,
  input  logic clrwdt_i,
  input  logic clk_lost_i,
  input  logic mon_en_i,
  input  logic freq_wr_i,
  input  logic intosc_sys_i,
  output logic clr_o
);
  logic [N_CLR_SRC-1:0] src;

  always_comb begin
    src[0] = sleep_i;
    src[1] = clrwdt_i;
    src[2] = clk_lost_i & mon_en_i;     // only with monitoring on
    src[3] = freq_wr_i & intosc_sys_i;  // only when internal osc is sysclk
  end

  assign clr_o = |src;
endmodule

// File: rtl/wdt_base.sv
module wdt_base #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic             carry_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i || clr_i) cnt_q <= '0;
    else if (tick_i)         cnt_q <= cnt_q + CNT_W'(1);
  end

  // clear suppresses the carry in the same cycle
  assign carry_o = en_i & ~clr_i & tick_i & (&cnt_q);
  assign cnt_o   = cnt_q;

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R10
  en_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int PS_W  = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             carry_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  logic [PS_W-1:0] post_q;
  logic [PS_W-1:0] mask;

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign mask[i] = (int'(sel_i) > i);
  end

  assign expire_o = carry_i & ((post_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             post_q <= '0;
    else if (!en_i || clr_i) post_q <= '0;
    else if (carry_i) begin
      if (expire_o) post_q <= '0;
      else          post_q <= post_q + PS_W'(1);
    end
  end

  // R9
  post_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> post_q == '0);
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       clrwdt_i,
  input  logic       expire_i,
  input  logic [1:0] pmode_i,
  output logic       wake_o,
  output logic       rst_o,
  output logic       to_o
);
  pmode_e mode;
  logic   wake_q, rst_q, to_q;

  assign mode = pmode_e'(pmode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= 1'b0;
      rst_q  <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      wake_q <= expire_i && (mode != PM_RUN);
      rst_q  <= expire_i && (mode == PM_RUN);
      if (clrwdt_i)      to_q <= 1'b0;
      else if (expire_i) to_q <= 1'b1;
    end
  end

  assign wake_o = wake_q;
  assign rst_o  = rst_q;
  assign to_o   = to_q;

  // R1
  wake_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> $past(pmode_i) != 2'd0);
  // R2
  rst_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> $past(pmode_i) == 2'd0);
  // R8
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_q && rst_q));
  // R8
  wake_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q);
  // R8
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  // R5
  to_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(to_q) |-> $past(clrwdt_i));
  // R9
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !(wake_q || rst_q));
  // R10
  en_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(wake_q || rst_q));
endmodule

// File: rtl/pm_watchdog.sv
module pm_watchdog #(
  parameter  int CNT_W = 8,
  parameter  int PS_W  = 15,
  localparam int SEL_W = $clog2(PS_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [1:0]       pmode_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  input  logic             sleep_i,
  input  logic             clrwdt_i,
  input  logic             clk_lost_i,
  input  logic             mon_en_i,
  input  logic             freq_wr_i,
  input  logic             intosc_sys_i,
  output logic             wake_o,
  output logic             rst_o,
  output logic             to_o
);
  logic             clr;
  logic             carry;
  logic             expire;
  logic [CNT_W-1:0] base_cnt;

  wdt_clr_gen u_clr (
    .sleep_i      (sleep_i),
    .clrwdt_i     (clrwdt_i),
    .clk_lost_i   (clk_lost_i),
    .mon_en_i     (mon_en_i),
    .freq_wr_i    (freq_wr_i),
    .intosc_sys_i (intosc_sys_i),
    .clr_o        (clr)
  );

  wdt_base #(.CNT_W(CNT_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .clr_i   (clr),
    .tick_i  (tick_i),
    .carry_o (carry),
    .cnt_o   (base_cnt)
  );

  wdt_post #(.PS_W(PS_W), .SEL_W(SEL_W)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .clr_i    (clr),
    .carry_i  (carry),
    .sel_i    (ps_sel_i),
    .expire_o (expire)
  );

  wdt_action u_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .clr_i    (clr),
    .clrwdt_i (clrwdt_i),
    .expire_i (expire),
    .pmode_i  (pmode_i),
    .wake_o   (wake_o),
    .rst_o    (rst_o),
    .to_o     (to_o)
  );

  // R9
  expire_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> !clr && base_cnt == '1);
endmodule

// File: tb/pm_watchdog_tb_top.sv
`timescale 1ns/1ps
module pm_watchdog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, tick = 1'b1;
  logic [1:0] pmode = 2'd0;
  logic [3:0] ps = 4'd0;
  logic sleep_s = 0, clrwdt = 0, clk_lost = 0, mon_en = 0, freq_wr = 0, intosc = 0;
  logic wake, rstp, to;

  int cyc = 0;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { bit is_rst; int at; string req; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_watchdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .pmode_i(pmode),
    .ps_sel_i(ps), .sleep_i(sleep_s), .clrwdt_i(clrwdt), .clk_lost_i(clk_lost),
    .mon_en_i(mon_en), .freq_wr_i(freq_wr), .intosc_sys_i(intosc),
    .wake_o(wake), .rst_o(rstp), .to_o(to)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_pulse(bit is_rst, int at, string req);
    exp_t e;
    e.is_rst = is_rst; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares every observed pulse with the scoreboard head
  bit prev_pulse = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        exp_t m;
        m = q.pop_front();
        chk(0, m.req, "missing pulse at cycle", cyc, m.at);
      end
      if (wake || rstp) begin
        chk(!prev_pulse, "R8", "pulse width", 2, 1);
        if (q.size() == 0) chk(0, "R9/R10", "unexpected pulse at cycle", cyc, -1);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.at == cyc, e.req, "pulse cycle", cyc, e.at);
          chk(rstp == e.is_rst && wake == !e.is_rst, e.req, "pulse kind rst", int'(rstp), int'(e.is_rst));
        end
      end
      prev_pulse = wake || rstp;
    end
  end

  // which: 0 sleep, 1 clrwdt, 2 clk_lost, 3 freq_wr; called at a negedge
  task automatic strobe(int which, output int b);
    case (which)
      0: sleep_s = 1;
      1: clrwdt = 1;
      2: clk_lost = 1;
      default: freq_wr = 1;
    endcase
    @(negedge clk);
    sleep_s = 0; clrwdt = 0; clk_lost = 0; freq_wr = 0;
    b = cyc;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "timeout cycles", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b, p;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(wake == 0, "R8", "wake in reset", int'(wake), 0);
    chk(rstp == 0, "R8", "rst in reset", int'(rstp), 0);
    chk(to == 0, "R8", "to in reset", int'(to), 0);
    rst_n = 1;
    b = cyc;
    // R2 R3: run mode, ratio 1
    expect_pulse(1, b + 256, "R2");
    wait_until(b + 258);
    chk(to == 1, "R8", "to after reset pulse", int'(to), 1);

    // R1 R5: idle, ratio 2, cleared by clrwdt
    pmode = 2'd1; ps = 4'd1;
    strobe(1, b);
    chk(to == 0, "R5", "to after clrwdt", int'(to), 0);
    expect_pulse(0, b + 512, "R1");
    wait_until(b + 514);
    chk(to == 1, "R8", "to after wake", int'(to), 1);

    // R4: sleep, ratio 4, cleared by sleep; to_o kept
    pmode = 2'd2; ps = 4'd2;
    strobe(0, b);
    chk(to == 1, "R4", "to after sleep strobe", int'(to), 1);
    expect_pulse(0, b + 1024, "R4");
    wait_until(b + 1030);

    // R6: clk_lost without monitoring ignored, with monitoring clears
    pmode = 2'd0; ps = 4'd0;
    strobe(1, b);
    expect_pulse(1, b + 256, "R6");
    wait_until(b + 100);
    mon_en = 0;
    strobe(2, p);
    wait_until(b + 300);
    mon_en = 1;
    strobe(2, b);
    mon_en = 0;
    expect_pulse(1, b + 256, "R6");
    wait_until(b + 256);
    p = b + 256;

    // R7: freq write ignored without internal osc, clears with it
    wait_until(p + 50);
    intosc = 0;
    strobe(3, b);
    expect_pulse(1, p + 256, "R7");
    wait_until(p + 300);
    intosc = 1;
    strobe(3, b);
    intosc = 0;

    // R9: clear in the terminal-tick cycle wins
    wait_until(b + 255);
    strobe(1, b);
    chk(b == p + 300 + 257, "R9", "collision base cycle", b, p + 557);
    expect_pulse(1, b + 256, "R9");
    wait_until(b + 266);

    // R10: enable low holds zero, no pulses
    en = 0;
    repeat (700) @(negedge clk);
    en = 1;
    b = cyc;
    expect_pulse(1, b + 256, "R10");
    wait_until(b + 266);

    // R3 R1: tick gating, mode 11 wakes, ratio 8
    pmode = 2'd3; ps = 4'd3;
    tick = 0;
    strobe(1, b);
    repeat (1500) @(negedge clk);
    tick = 1;
    b = cyc;
    expect_pulse(0, b + 2048, "R3");
    wait_until(b + 2055);

    chk(q.size() == 0, "R3", "leftover expectations", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule